// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is a small sum-of-products array in which both planes can be reprogrammed. The AND plane holds one literal mask for each product term. The OR plane holds one term mask for each output. Each output is the OR of the product terms selected for it, and each product term is the AND of the literals selected for it. A product term may feed any number of outputs, so the terms are shared. The outputs depend only on the current inputs and the stored masks, through combinational logic alone.

Software, or a boot sequencer, loads the masks one entry at a time through a single synchronous write port. After that the block acts as a fixed multi-output logic function. A function that needs more distinct product terms than the array provides cannot be programmed. For that reason the array is less general than a lookup table with the same number of inputs. The default size is three inputs, four terms and three outputs. This is enough for a reference set of three functions that share four terms.

Top module: `pla_array`

## Requirements
- R1: The parameters default to N_IN=3 inputs, N_TERM=4 product terms and N_OUT=3 outputs. The default cfg_idx is 2 bits wide and the default cfg_data is 6 bits wide.
- R2: In each AND-plane entry, bit 2i selects the true literal of pla_in[i] and bit 2i+1 selects its complement. A term is 1 exactly when every literal it selects holds.
- R3: A term whose entry sets both bits for the same input always evaluates to 0.
- R4: A term whose entry selects no literal always evaluates to 1.
- R5: In the OR-plane entry for output j, bit t includes product term t. pla_out[j] is the OR of the included terms, and it is 0 when no term is included.
- R6: One product term can drive several outputs at the same time.
- R7: A write happens when cfg_we is 1 at a rising clock edge. cfg_sel 0 addresses the AND plane and cfg_sel 1 addresses the OR plane. cfg_idx picks the entry and the low bits of cfg_data give its value. The new value does not change the outputs before that edge.
- R8: A write whose cfg_idx is at or above the entry count of the addressed plane has no effect.
- R9: A synchronous reset clears every entry of both planes, so every output is 0 after reset for every input code.
- R10: When pla_in changes, pla_out follows without waiting for a clock edge.
- R11: With x=pla_in[2], y=pla_in[1] and z=pla_in[0], the four terms x'yz', xy, xy'z' and x'z can be programmed. pla_out[2] is then 1 for codes 1, 2, 3 and 4. pla_out[1] is 1 for codes 2, 6 and 7. pla_out[0] is 1 for codes 4, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the plane registers |
| rst | input | 1 | Synchronous reset, active high, clears both planes |
| cfg_we | input | 1 | Write strobe for one plane entry |
| cfg_sel | input | 1 | Plane select: 0 is the AND plane, 1 is the OR plane |
| cfg_idx | input | IDX_W | Entry index: a term for the AND plane, an output for the OR plane |
| cfg_data | input | CFG_W | Entry value: literal mask or term mask |
| pla_in | input | N_IN | Logic inputs |
| pla_out | output | N_OUT | Sum-of-products outputs |

## Verification
The bench sets up the two empty cases on purpose. A term with no literals must read as 1 and an output with no terms must read as 0. A design that swapped these identities would show every output high after reset, or would lose the always-true term. It also programs a term with conflicting true and complement literals. A design that let either literal win would pass that term through for half of the input codes. It writes an index past the OR plane. A design that decoded the index modulo the entry count would corrupt a real output. It probes the outputs before and after the edge of a write, which catches any path from the write port to the outputs that skips the register. Finally it compares the reference programming against a minterm model on all eight codes, where one missing shared term breaks two outputs at once.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic {
        PLANE_AND = 1'b0,
        PLANE_OR  = 1'b1
    } plane_e;

    function automatic int idx_width(input int n_term, input int n_out);
        int cnt;
        cnt = (n_term > n_out) ? n_term : n_out;
        return (cnt > 1) ? $clog2(cnt) : 1;
    endfunction

    function automatic int data_width(input int n_in, input int n_term);
        return (2 * n_in > n_term) ? 2 * n_in : n_term;
    endfunction

endpackage

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [2*N_IN-1:0] wr_mask,
    input  logic [N_IN-1:0]   pla_in,
    output logic [N_TERM-1:0] terms
);
    localparam int LIT_W = 2 * N_IN;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [LIT_W-1:0] lit_q;
        logic             hit;

        assign hit = wr_en && (wr_idx == IDX_W'(t));

        always_ff @(posedge clk) begin
            if (rst) begin
                lit_q <= '0;
            end else if (hit) begin
                lit_q <= wr_mask;
            end
        end

        always_comb begin
            terms[t] = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                if (lit_q[2*i] && !pla_in[i]) begin
                    terms[t] = 1'b0;
                end
                if (lit_q[2*i+1] && pla_in[i]) begin
                    terms[t] = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_TERM = 4,
    parameter int N_OUT  = 3,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [N_TERM-1:0] wr_mask,
    input  logic [N_TERM-1:0] terms,
    output logic [N_OUT-1:0]  pla_out
);

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        logic [N_TERM-1:0] sum_q;
        logic              hit;

        assign hit = wr_en && (wr_idx == IDX_W'(j));

        always_ff @(posedge clk) begin
            if (rst) begin
                sum_q <= '0;
            end else if (hit) begin
                sum_q <= wr_mask;
            end
        end

        assign pla_out[j] = |(sum_q & terms);
    end

endmodule

// File: rtl/pla_array.sv
module pla_array #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4,
    parameter int N_OUT  = 3,
    parameter int IDX_W  = pla_pkg::idx_width(N_TERM, N_OUT),
    parameter int CFG_W  = pla_pkg::data_width(N_IN, N_TERM)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic [N_IN-1:0]  pla_in,
    output logic [N_OUT-1:0] pla_out
);
    import pla_pkg::*;

    logic [N_TERM-1:0] terms;
    logic              and_we;
    logic              or_we;

    assign and_we = cfg_we && (plane_e'(cfg_sel) == PLANE_AND);
    assign or_we  = cfg_we && (plane_e'(cfg_sel) == PLANE_OR);

    pla_and_plane #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM),
        .IDX_W  (IDX_W)
    ) u_and (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (and_we),
        .wr_idx  (cfg_idx),
        .wr_mask (cfg_data[2*N_IN-1:0]),
        .pla_in  (pla_in),
        .terms   (terms)
    );

    pla_or_plane #(
        .N_TERM (N_TERM),
        .N_OUT  (N_OUT),
        .IDX_W  (IDX_W)
    ) u_or (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (or_we),
        .wr_idx  (cfg_idx),
        .wr_mask (cfg_data[N_TERM-1:0]),
        .terms   (terms),
        .pla_out (pla_out)
    );

endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4,
    parameter int N_OUT  = 3,
    parameter int IDX_W  = 2,
    parameter int CFG_W  = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic             cfg_sel,
    input logic [IDX_W-1:0] cfg_idx,
    input logic [CFG_W-1:0] cfg_data,
    input logic [N_IN-1:0]  pla_in,
    input logic [N_OUT-1:0] pla_out
);

    // R9: the first cycle after reset shows cleared planes
    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pla_out == '0));

    // R10 / R7: with no write and steady inputs the outputs hold
    assert_hold_steady_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_we ##1 $stable(pla_in) |-> $stable(pla_out));

    // R8: OR-plane write past the last output changes nothing
    assert_or_range_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_sel && (int'(cfg_idx) >= N_OUT) ##1 $stable(pla_in)
            |-> $stable(pla_out));

    // R8: AND-plane write past the last term changes nothing
    assert_and_range_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_we && !cfg_sel && (int'(cfg_idx) >= N_TERM) ##1 $stable(pla_in)
            |-> $stable(pla_out));

    // R5: an output written with an empty term mask reads 0 next cycle
    for (genvar j = 0; j < N_OUT; j++) begin : g_empty
        assert_empty_sum_R5: assert property (@(posedge clk) disable iff (rst)
            cfg_we && cfg_sel && (cfg_idx == IDX_W'(j)) && (cfg_data[N_TERM-1:0] == '0)
                |=> !pla_out[j]);
    end

endmodule

bind pla_array pla_array_chk #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM),
    .N_OUT  (N_OUT),
    .IDX_W  (IDX_W),
    .CFG_W  (CFG_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_idx  (cfg_idx),
    .cfg_data (cfg_data),
    .pla_in   (pla_in),
    .pla_out  (pla_out)
);

// File: tb/pla_array_bench.sv
`timescale 1ns/1ps
module pla_array_bench;

    typedef struct {
        logic [2:0] code;
        logic [2:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [1:0] cfg_idx = '0;
    logic [5:0] cfg_data = '0;
    logic [2:0] pla_in = '0;
    logic [2:0] pla_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #2 clk = ~clk;

    pla_array u_pla_array (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_idx  (cfg_idx),
        .cfg_data (cfg_data),
        .pla_in   (pla_in),
        .pla_out  (pla_out)
    );

    function automatic logic [2:0] rom_model(input logic [2:0] c);
        logic [2:0] v;
        v[2] = (c == 3'd1) || (c == 3'd2) || (c == 3'd3) || (c == 3'd4);
        v[1] = (c == 3'd2) || (c == 3'd6) || (c == 3'd7);
        v[0] = (c == 3'd4) || (c == 3'd6) || (c == 3'd7);
        return v;
    endfunction

    task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pla_out=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic expect_out(input logic [2:0] code, input logic [2:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        pla_in = code;
        it.code = code;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
        @(posedge clk);
    endtask

    task automatic cfg_write(input logic sel, input logic [1:0] idx, input logic [5:0] data);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_sel  = sel;
        cfg_idx  = idx;
        cfg_data = data;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    // monitor: pops expected items and compares mid-cycle
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check(pla_out, it.exp, it.tag);
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: pla_out=%b expected completion", pla_out);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 R1: cleared planes give 0 for every code
        for (int c = 0; c < 8; c++) expect_out(3'(c), 3'b000, "R9 after reset");

        // R4: term 0 with no literals, output 0 sums term 0 only
        cfg_write(1'b0, 2'd0, 6'b000000);
        cfg_write(1'b1, 2'd0, 6'b000001);
        for (int c = 0; c < 8; c++) expect_out(3'(c), 3'b001, "R4 empty term is 1");

        // R3: term 1 wants both literals of input 0, output 1 sums term 1
        cfg_write(1'b0, 2'd1, 6'b000011);
        cfg_write(1'b1, 2'd1, 6'b000010);
        for (int c = 0; c < 8; c += 3) expect_out(3'(c), 3'b001, "R3 conflicting literals");

        // R7: the write is invisible until its edge
        @(negedge clk);
        pla_in   = 3'd5;
        cfg_we   = 1'b1;
        cfg_sel  = 1'b0;
        cfg_idx  = 2'd1;
        cfg_data = 6'b000000;
        #1;
        check(pla_out, 3'b001, "R7 before edge");
        @(negedge clk);
        cfg_we = 1'b0;
        expect_out(3'd5, 3'b011, "R7 after edge");

        // R8: OR-plane index 3 is out of range
        cfg_write(1'b1, 2'd3, 6'b000000);
        expect_out(3'd2, 3'b011, "R8 out-of-range write");

        // R11 R2 R5 R6: reference programming
        cfg_write(1'b0, 2'd0, 6'b100110);   // x'yz'
        cfg_write(1'b0, 2'd1, 6'b010100);   // xy
        cfg_write(1'b0, 2'd2, 6'b011010);   // xy'z'
        cfg_write(1'b0, 2'd3, 6'b100001);   // x'z
        cfg_write(1'b1, 2'd2, 6'b001101);
        cfg_write(1'b1, 2'd1, 6'b000011);
        cfg_write(1'b1, 2'd0, 6'b000110);
        for (int c = 0; c < 8; c++) expect_out(3'(c), rom_model(3'(c)), "R11 reference vs ROM");

        // R10: outputs follow inputs without a clock edge
        @(negedge clk);
        pla_in = 3'd3;
        #1;
        check(pla_out, rom_model(3'd3), "R10 combinational code 3");
        pla_in = 3'd6;
        #0.5;
        check(pla_out, rom_model(3'd6), "R10 combinational code 6");

        // R6: term xy shared by all three outputs
        cfg_write(1'b1, 2'd2, 6'b000010);
        expect_out(3'd7, 3'b111, "R6 shared term code 7");
        expect_out(3'd4, 3'b001, "R6 shared term code 4");

        // R9: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        expect_out(3'd6, 3'b000, "R9 reset clears code 6");
        expect_out(3'd7, 3'b000, "R9 reset clears code 7");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule